// File: doc/BRIEF.md
# Supervised Memory Access Unit

This unit holds a small word-addressed memory in which every word carries a data value and a separate 2-bit metastate. Supervised loads and stores first look at the word's metastate. They then find the next metastate in a transition table that software programs. The table is indexed by the kind of access (read or write) and by the current metastate. If the table returns the reserved exception code, the access is abandoned and the response tells the requester to jump to its handler. In that case neither data nor metastate is touched.

Otherwise the data is read or written. The metastate is written back only when the table gives a state different from the current one. Software gives the states their meaning. Examples are "never written" versus "written", or "empty" versus "full". A read of a word that was never written can therefore be trapped. Plain loads and stores bypass the metastate entirely.

Only one request is in flight at a time. The metastate read, the table check, the data access and the metastate write-back all happen in a single execute cycle before the next request is accepted, so the sequence is atomic with respect to other requests.

Top module: `sup_mem_unit`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. Every word's data and metastate are 0, and every transition-table entry is 0.
- R2: When tbl_we is 1 at a clock edge, the table entry at tbl_idx takes tbl_val. The index is {access_is_write, current_state}: bit 2 selects the write column and bits 1:0 hold the current metastate.
- R3: A request is accepted at an edge where req_valid and req_ready are both 1. req_ready is 0 at the next edge. rsp_valid is 1 for exactly one cycle, after the second edge that follows acceptance, and req_ready is 1 again in that same cycle.
- R4: req_op encodes the access as follows: 0 is a plain load, 1 is a plain store, 2 is a supervised load and 3 is a supervised store.
- R5: For a supervised load whose next state is not 3, rsp_rdata is the word's data, rsp_meta is its current metastate and rsp_jump is 0. The word's metastate becomes the next state.
- R6: For a supervised store whose next state is not 3, the word's data becomes req_wdata and its metastate becomes the next state. rsp_meta is the prior metastate.
- R7: When the next state is 3 (exception), rsp_jump is 1 and rsp_rdata is 0. rsp_meta shows the current metastate, and the word's data and metastate are unchanged.
- R8: Plain loads and stores read or write data only. They leave the metastate unchanged and answer with rsp_jump 0 and rsp_meta 0.
- R9: Every store response has rsp_rdata equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Transition-table write strobe |
| tbl_idx | input | 3 | Table entry: {is_write, current_state} |
| tbl_val | input | 2 | Next state to store in the entry |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | Access kind (see R4) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Load data, 0 otherwise |
| rsp_jump | output | 1 | Handler jump requested |
| rsp_meta | output | 2 | Metastate observed before the access |

## Verification
A fixed read-before-write tracker table is tried first. It shows that a load of a never-written word traps, that a store moves the word into the written state, and that the later load returns the data. Several pseudo-random transition tables then drive long mixed sequences of all four access kinds over every address, against a bench model of data, metastate and table. These runs separate the state-changing path from the unchanged-state path and the trapping path, and they separate supervised accesses from plain ones. A plain access wedged between supervised ones shows through the next rsp_meta whether it touched the metastate.

// File: rtl/smu_pkg.sv
package smu_pkg;
  localparam int META_W = 2;
  localparam int N_STATES = 1 << META_W;
  localparam int TBL_N = 2 * N_STATES;
  localparam int TBL_IW = META_W + 1;
  localparam logic [META_W-1:0] META_EXC = '1;

  typedef enum logic [1:0] {
    OP_LD  = 2'd0,
    OP_ST  = 2'd1,
    OP_SLD = 2'd2,
    OP_SST = 2'd3
  } op_e;

  function automatic logic op_is_sup(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_write(input logic [1:0] op);
    return op[0];
  endfunction

  function automatic logic [TBL_IW-1:0] tbl_index(input logic [1:0] op,
                                                  input logic [META_W-1:0] cur);
    return {op[0], cur};
  endfunction
endpackage

// File: rtl/smu_trans_table.sv
module smu_trans_table
  import smu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TBL_IW-1:0] wr_idx,
  input  logic [META_W-1:0] wr_val,
  input  logic [TBL_IW-1:0] rd_idx,
  output logic [META_W-1:0] rd_val
);
  logic [META_W-1:0] entry_q [TBL_N];

  for (genvar g = 0; g < TBL_N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) entry_q[g] <= '0;
      else if (wr_en && wr_idx == TBL_IW'(g)) entry_q[g] <= wr_val;
    end
  end

  assign rd_val = entry_q[rd_idx];
endmodule

// File: rtl/smu_store.sv
module smu_store
  import smu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wr,
  input  logic              meta_we,
  input  logic [META_W-1:0] meta_wr,
  output logic [DATA_W-1:0] data_rd,
  output logic [META_W-1:0] meta_rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [META_W-1:0] meta_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        meta_q[g] <= '0;
      end else if (addr == ADDR_W'(g)) begin
        if (data_we) data_q[g] <= data_wr;
        if (meta_we) meta_q[g] <= meta_wr;
      end
    end
  end

  assign data_rd = data_q[addr];
  assign meta_rd = meta_q[addr];
endmodule

// File: rtl/sup_mem_unit.sv
module sup_mem_unit
  import smu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [2:0]        tbl_idx,
  input  logic [1:0]        tbl_val,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_jump,
  output logic [1:0]        rsp_meta
);
  typedef enum logic {ST_IDLE, ST_EXEC} phase_e;

  phase_e            phase_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // named internal events
  logic              accept;
  logic              in_exec;
  logic              exec_sup;
  logic [META_W-1:0] cur_meta;
  logic [META_W-1:0] nxt_meta;
  logic              exc_hit;
  logic              data_we;
  logic              meta_we;
  logic [DATA_W-1:0] data_rd;

  assign req_ready = (phase_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_exec   = (phase_q == ST_EXEC);
  assign exec_sup  = in_exec && op_is_sup(op_q);

  smu_trans_table u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_we),
    .wr_idx (tbl_idx),
    .wr_val (tbl_val),
    .rd_idx (tbl_index(op_q, cur_meta)),
    .rd_val (nxt_meta)
  );

  smu_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr_q),
    .data_we (data_we),
    .data_wr (wdata_q),
    .meta_we (meta_we),
    .meta_wr (nxt_meta),
    .data_rd (data_rd),
    .meta_rd (cur_meta)
  );

  assign exc_hit = exec_sup && (nxt_meta == META_EXC);
  assign data_we = in_exec && op_is_write(op_q) && !exc_hit;
  assign meta_we = exec_sup && !exc_hit && (nxt_meta != cur_meta);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= ST_IDLE;
      op_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_jump  <= 1'b0;
      rsp_meta  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        phase_q <= ST_EXEC;
        op_q    <= req_op;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end else if (in_exec) begin
        phase_q   <= ST_IDLE;
        rsp_valid <= 1'b1;
        rsp_jump  <= exc_hit;
        rsp_meta  <= exec_sup ? cur_meta : '0;
        rsp_rdata <= (!op_is_write(op_q) && !exc_hit) ? data_rd : '0;
      end
    end
  end
endmodule

// File: rtl/smu_checker.sv
module smu_checker
  import smu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_jump,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              exec_sup,
  input logic              exc_hit,
  input logic              data_we,
  input logic              meta_we,
  input logic [META_W-1:0] cur_meta,
  input logic [META_W-1:0] nxt_meta
);
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_resp_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 rsp_valid);

  assert_resp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_meta_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meta_we |-> (nxt_meta != cur_meta) && (nxt_meta != META_EXC));

  assert_exc_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_hit |-> !data_we && !meta_we);

  assert_jump_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_jump) |-> rsp_rdata == '0);

  assert_plain_no_meta_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meta_we |-> exec_sup);
endmodule

bind sup_mem_unit smu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_jump  (rsp_jump),
  .rsp_rdata (rsp_rdata),
  .exec_sup  (exec_sup),
  .exc_hit   (exc_hit),
  .data_we   (data_we),
  .meta_we   (meta_we),
  .cur_meta  (cur_meta),
  .nxt_meta  (nxt_meta)
);

// File: tb/sup_mem_unit_tb.sv
module sup_mem_unit_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [1:0] tbl_val = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic rsp_jump;
  logic [1:0] rsp_meta;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] m_data [DEPTH];
  logic [1:0] m_meta [DEPTH];
  logic [1:0] m_tbl [8];
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  sup_mem_unit #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // R2: program one entry, index {is_write, state}
  task automatic prog(input int idx, input logic [1:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_val = v;
    @(negedge clk);
    tbl_we = 1'b0;
    m_tbl[idx] = v;
  endtask

  // R4 encoding: 0 ld, 1 st, 2 sld, 3 sst
  task automatic do_op(input logic [1:0] op, input int a, input logic [DW-1:0] wd);
    logic sup, wr;
    logic [1:0] cur, nxt;
    logic [DW-1:0] exp_rd;
    logic exp_j;
    logic [1:0] exp_m;
    sup = op[1]; wr = op[0];
    cur = m_meta[a];
    nxt = m_tbl[{wr, cur}];
    exp_j = sup && (nxt == 2'd3);
    exp_m = sup ? cur : 2'd0;
    exp_rd = (!wr && !exp_j) ? m_data[a] : '0;
    if (!exp_j) begin
      if (wr) m_data[a] = wd;
      if (sup) m_meta[a] = nxt;
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready && !rsp_valid, "R3", "busy ready/valid", {req_ready, rsp_valid}, 0);
    @(negedge clk);
    check(rsp_valid && req_ready, "R3", "response ready/valid", {req_ready, rsp_valid}, 3);
    if (!sup)
      check(rsp_jump == 0 && rsp_meta == 0, "R8", "plain jump/meta", {rsp_jump, rsp_meta}, 0);
    else if (exp_j)
      check(rsp_jump && rsp_rdata == 0 && rsp_meta == exp_m, "R7", "trap jump/rdata/meta",
            {rsp_jump, rsp_rdata, rsp_meta}, {1'b1, 8'd0, exp_m});
    else
      check(!rsp_jump && rsp_meta == exp_m, wr ? "R6" : "R5", "jump/meta",
            {rsp_jump, rsp_meta}, {1'b0, exp_m});
    if (wr)
      check(rsp_rdata == 0, "R9", "store rdata", rsp_rdata, 0);
    else
      check(rsp_rdata == exp_rd, sup ? "R5" : "R8", "load rdata", rsp_rdata, exp_rd);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_meta[i] = '0; end
    for (int i = 0; i < 8; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1 && rsp_valid == 0, "R1", "reset ready/valid", {req_ready, rsp_valid}, 2);
    rst_n = 1'b1;
    // R1: zero table keeps state 0; sweep all words through supervised loads
    for (int a = 0; a < DEPTH; a++) do_op(2'd2, a, '0);
    // tracker: state0 unwritten, state1 written
    prog(0, 2'd3); prog(1, 2'd1); prog(4, 2'd1); prog(5, 2'd1);
    do_op(2'd2, 5, '0);        // R7 trap on read before write
    do_op(2'd2, 5, '0);        // R7 state left unchanged
    do_op(2'd1, 5, 8'hA5);     // R8 plain store, metastate stays 0
    do_op(2'd2, 5, '0);        // still traps
    do_op(2'd3, 5, 8'h3C);     // R6 supervised store
    do_op(2'd2, 5, '0);        // R5 returns 3C, meta 1
    do_op(2'd0, 5, '0);        // R8 plain load
    // random tables (R2) with random ops
    for (int t = 0; t < 6; t++) begin
      for (int e = 0; e < 8; e++) prog(e, 2'(rnd() >> 7));
      for (int n = 0; n < 300; n++) begin
        logic [31:0] r;
        r = rnd();
        do_op(2'(r >> 3), int'(r >> 9) % DEPTH, 8'(r >> 17));
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule